// File: doc/BRIEF.md
# Tuning Tap Window Selector

After a sampling-clock tuning sweep, each of the N delay taps has been probed twice. The two laps of probes form a pass/fail map of 2N bits. Bit i belongs to tap i mod N, and 1 means the probe passed. This block takes that map on a start pulse and walks it one bit per clock. It keeps the longest unbroken run of passes. It then reports the tap at the middle of that run, folded back into the range 0..N-1. If no run is long enough to trust, it reports a failure.

The map covers two laps of the tap ring. Because of this, a passing window that wraps from the highest tap back to tap 0 appears as one contiguous run and is found. Running the probes and driving the card are handled elsewhere. This block only turns the finished map into a decision.

Top module: `tap_window_select`

## Requirements
- R1: After reset, `done_o`, `fail_o` and `tap_o` are all 0.
- R2: A `start_i` pulse sampled while idle captures `probe_map_i`. `done_o` then goes high for exactly one cycle, on the 2N+2nd rising edge after the edge that sampled `start_i`.
- R3: The result comes from the longest run of consecutive 1 bits in the map. With the run's first index s and last index e, the tap is floor((s+e)/2) mod N.
- R4: When two runs have the same length, the run with the lower starting index wins.
- R5: A run that is still open at bit 2N-1 is compared against the best run as if a 0 followed it.
- R6: A run whose centre index is N or more is reported as centre minus N, so a window that wraps across the lap boundary selects a tap within 0..N-1.
- R7: If the best run is shorter than 3 (parameter `MIN_RUN`), `fail_o` is 1 and `tap_o` is 0. A run of exactly 3 is accepted with `fail_o` at 0.
- R8: A map of all zeros gives `fail_o`=1. A map of all ones gives tap ((2N-1)/2) mod N, which is 7 for N=8.
- R9: A `start_i` pulse that arrives while a scan is running is ignored. The running scan finishes at its original time with a result from the map it captured.
- R10: `fail_o` and `tap_o` keep their values from one `done_o` pulse until the next, including during a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| probe_map_i | input | 2*NUM_TAPS | Pass/fail map, bit i belongs to tap i mod NUM_TAPS |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| fail_o | output | 1 | No run of at least MIN_RUN passes was found |
| tap_o | output | clog2(NUM_TAPS) | Selected tap, 0 on failure |

## Verification
Directed maps separate the scan rules from one another. The all-zero and all-one maps cover the two extremes. A run of exactly three sits at the acceptance threshold, and a run of two falls just below it. Two equal runs whose middles fold to different taps show the tie rule. A run that reaches the last bit shows that the open run is closed at the end. A window straddling bit N shows the fold back into range. Random maps at sparse, even and dense pass densities are checked against a reference scan in the bench. A second start issued mid-scan shows that the running result is neither disturbed nor delayed.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_CLOSE  = 2'd2,
    ST_REPORT = 2'd3
  } tws_state_e;
endpackage

// File: rtl/tws_seq.sv
module tws_seq
  import tws_pkg::*;
#(
  parameter int NUM_TAPS = 8,
  localparam int MAP_W   = 2 * NUM_TAPS,
  localparam int IDXW    = $clog2(MAP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [MAP_W-1:0] map_i,
  output logic             clear_o,
  output logic             step_o,
  output logic             bit_o,
  output logic [IDXW-1:0]  idx_o,
  output logic             report_o
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(MAP_W - 1);
  localparam logic [IDXW-1:0] END_IDX  = IDXW'(MAP_W);

  tws_state_e       state_q, state_d;
  logic [IDXW-1:0]  idx_q, idx_d;
  logic [MAP_W-1:0] map_q, map_d;
  logic [MAP_W-1:0] shifted;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    map_d   = map_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SCAN;
          idx_d   = '0;
          map_d   = map_i;
        end
      end
      ST_SCAN: begin
        idx_d = idx_q + IDXW'(1);
        if (idx_q == LAST_IDX) state_d = ST_CLOSE;
      end
      ST_CLOSE:  state_d = ST_REPORT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      map_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      map_q   <= map_d;
    end
  end

  assign shifted  = map_q >> idx_q;
  assign clear_o  = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_SCAN) || (state_q == ST_CLOSE);
  assign bit_o    = (state_q == ST_SCAN) ? shifted[0] : 1'b0;
  assign idx_o    = idx_q;
  assign report_o = (state_q == ST_REPORT);

  // R9: the captured map cannot change while a scan is in flight
  a_r9_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(map_q));

  // R5: the closing step always sits one past the last map bit
  a_r5_close_index: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLOSE) |-> (idx_q == END_IDX));
endmodule

// File: rtl/tws_run_track.sv
module tws_run_track #(
  parameter int NUM_TAPS = 8,
  localparam int MAP_W   = 2 * NUM_TAPS,
  localparam int IDXW    = $clog2(MAP_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic            bit_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [IDXW-1:0] best_len_o,
  output logic [IDXW-1:0] best_start_o,
  output logic [IDXW-1:0] best_end_o
);
  logic [IDXW-1:0] cur_q, cur_d;
  logic [IDXW-1:0] best_q, best_d;
  logic [IDXW-1:0] bs_q, bs_d;
  logic [IDXW-1:0] be_q, be_d;

  always_comb begin
    cur_d  = cur_q;
    best_d = best_q;
    bs_d   = bs_q;
    be_d   = be_q;
    if (clear_i) begin
      cur_d  = '0;
      best_d = '0;
      bs_d   = '0;
      be_d   = '0;
    end else if (step_i) begin
      if (bit_i) begin
        cur_d = cur_q + IDXW'(1);
      end else begin
        if (cur_q > best_q) begin
          best_d = cur_q;
          bs_d   = idx_i - cur_q;
          be_d   = idx_i - IDXW'(1);
        end
        cur_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      bs_q   <= '0;
      be_q   <= '0;
    end else begin
      cur_q  <= cur_d;
      best_q <= best_d;
      bs_q   <= bs_d;
      be_q   <= be_d;
    end
  end

  assign best_len_o   = best_q;
  assign best_start_o = bs_q;
  assign best_end_o   = be_q;

  // R3: the best length never shrinks within one scan
  a_r3_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (best_q >= $past(best_q)));

  // R3: the recorded span matches the recorded length
  a_r3_span_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (best_q != '0) |-> ((be_q - bs_q + IDXW'(1)) == best_q));

  // R5: an open run can never be longer than the bits already seen
  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cur_q <= idx_i));
endmodule

// File: rtl/tws_fold.sv
module tws_fold #(
  parameter int NUM_TAPS = 8,
  parameter int MIN_RUN  = 3,
  localparam int MAP_W   = 2 * NUM_TAPS,
  localparam int IDXW    = $clog2(MAP_W + 1),
  localparam int TAPW    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic [IDXW-1:0] best_len_i,
  input  logic [IDXW-1:0] best_start_i,
  input  logic [IDXW-1:0] best_end_i,
  output logic            fail_o,
  output logic [TAPW-1:0] tap_o
);
  localparam logic [IDXW-1:0] TAPS_I = IDXW'(NUM_TAPS);
  localparam logic [IDXW-1:0] MIN_I  = IDXW'(MIN_RUN);

  logic [IDXW:0]   sum;
  logic [IDXW-1:0] centre;
  logic [IDXW-1:0] folded;

  always_comb begin
    sum    = {1'b0, best_start_i} + {1'b0, best_end_i};
    centre = sum[IDXW:1];
    folded = (centre >= TAPS_I) ? (centre - TAPS_I) : centre;
    fail_o = (best_len_i < MIN_I);
    tap_o  = fail_o ? '0 : folded[TAPW-1:0];
  end
endmodule

// File: rtl/tap_window_select.sv
module tap_window_select #(
  parameter int NUM_TAPS = 8,
  parameter int MIN_RUN  = 3,
  localparam int MAP_W   = 2 * NUM_TAPS,
  localparam int IDXW    = $clog2(MAP_W + 1),
  localparam int TAPW    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [MAP_W-1:0] probe_map_i,
  output logic             done_o,
  output logic             fail_o,
  output logic [TAPW-1:0]  tap_o
);
  logic            clear, step, scan_bit, report;
  logic [IDXW-1:0] idx, best_len, best_start, best_end;
  logic            fail_c;
  logic [TAPW-1:0] tap_c;

  logic            done_q, done_d;
  logic            fail_q, fail_d;
  logic [TAPW-1:0] tap_q, tap_d;

  tws_seq #(.NUM_TAPS(NUM_TAPS)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .map_i    (probe_map_i),
    .clear_o  (clear),
    .step_o   (step),
    .bit_o    (scan_bit),
    .idx_o    (idx),
    .report_o (report)
  );

  tws_run_track #(.NUM_TAPS(NUM_TAPS)) track_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear),
    .step_i       (step),
    .bit_i        (scan_bit),
    .idx_i        (idx),
    .best_len_o   (best_len),
    .best_start_o (best_start),
    .best_end_o   (best_end)
  );

  tws_fold #(.NUM_TAPS(NUM_TAPS), .MIN_RUN(MIN_RUN)) fold_i (
    .best_len_i   (best_len),
    .best_start_i (best_start),
    .best_end_i   (best_end),
    .fail_o       (fail_c),
    .tap_o        (tap_c)
  );

  always_comb begin
    done_d = report;
    fail_d = report ? fail_c : fail_q;
    tap_d  = report ? tap_c  : tap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      tap_q  <= '0;
    end else begin
      done_q <= done_d;
      fail_q <= fail_d;
      tap_q  <= tap_d;
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;
  assign tap_o  = tap_q;

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: results move only when a report is issued
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !report |=> ($stable(fail_q) && $stable(tap_q)));

  // R7: a failed selection never carries a tap
  a_r7_fail_no_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fail_q) |-> (tap_q == '0));

  // R6: the reported tap is always inside the ring
  a_r6_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (int'(tap_q) < NUM_TAPS));
endmodule

// File: tb/tap_window_select_tb.sv
module tap_window_select_tb_top;
  localparam int N    = 8;
  localparam int W    = 2 * N;
  localparam int TAPW = $clog2(N);
  localparam int LAT  = W + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [W-1:0]    probe_map_i = '0;
  logic            done_o, fail_o;
  logic [TAPW-1:0] tap_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tap_window_select #(.NUM_TAPS(N), .MIN_RUN(3)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .probe_map_i (probe_map_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .tap_o       (tap_o)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void ref_pick(input logic [W-1:0] v, output int tap, output int fl);
    int best = 0, bs = 0, be = 0, cur = 0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) cur++;
      else begin
        if (cur > best) begin best = cur; bs = i - cur; be = i - 1; end
        cur = 0;
      end
    end
    if (cur > best) begin best = cur; bs = W - cur; be = W - 1; end
    fl  = (best < 3) ? 1 : 0;
    tap = fl ? 0 : ((bs + be) / 2) % N;
  endfunction

  // Launch one scan, wait for done, check latency, pulse width and result.
  task automatic run_case(input string req, input logic [W-1:0] v,
                          input int exp_tap, input int exp_fail);
    int cnt = 0;
    @(negedge clk);
    start_i = 1'b1;
    probe_map_i = v;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && cnt < 4 * LAT) begin
      @(negedge clk);
      cnt++;
    end
    check_eq("R2", "latency", cnt, LAT);
    check_eq(req, "fail", int'(fail_o), exp_fail);
    check_eq(req, "tap", int'(tap_o), exp_tap);
    @(negedge clk);
    check_eq("R2", "done width", int'(done_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    int rt, rf;
    seed_dummy = $urandom(32'd20161103);
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", "done", int'(done_o), 0);
    check_eq("R1", "fail", int'(fail_o), 0);
    check_eq("R1", "tap", int'(tap_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case("R8", 16'h0000, 0, 1);            // all zeros fail
    run_case("R8", 16'hFFFF, 7, 0);            // all ones -> 15/2 = 7
    run_case("R7", 16'h0007, 1, 0);            // run of exactly 3 accepted
    run_case("R7", 16'h6003, 0, 1);            // best run 2 -> fail
    run_case("R3", 16'h00F3, 5, 0);            // longer run 4..7 beats 0..1
    run_case("R4", 16'h1C0E, 2, 0);            // tie: 1..3 (tap 2) beats 10..12 (tap 3)
    run_case("R5", 16'hF003, 5, 0);            // open run 12..15, centre 13 -> 5
    run_case("R6", 16'h07C0, 0, 0);            // wrap window 6..10, centre 8 -> 0
    run_case("R6", 16'h3E00, 3, 0);            // window 9..13, centre 11 -> 3

    // R9 and R10: second start mid-scan is ignored; old result holds during scan
    begin
      int cnt = 0;
      @(negedge clk);
      start_i = 1'b1;
      probe_map_i = 16'h00F3;
      @(negedge clk);
      start_i = 1'b0;
      probe_map_i = 16'hFFFF;
      repeat (3) begin @(negedge clk); cnt++; end
      check_eq("R10", "tap during scan", int'(tap_o), 3);
      start_i = 1'b1;
      @(negedge clk);
      cnt++;
      start_i = 1'b0;
      while (!done_o && cnt < 4 * LAT) begin
        @(negedge clk);
        cnt++;
      end
      check_eq("R9", "latency", cnt, LAT);
      check_eq("R9", "tap", int'(tap_o), 5);
      check_eq("R9", "fail", int'(fail_o), 0);
      repeat (5) @(negedge clk);
      check_eq("R10", "tap after done", int'(tap_o), 5);
      check_eq("R10", "fail after done", int'(fail_o), 0);
      check_eq("R9", "no second done", int'(done_o), 0);
    end

    // R3: random maps at three pass densities against the reference scan
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] v;
      case ($urandom % 3)
        0:       v = W'($urandom & $urandom);
        1:       v = W'($urandom);
        default: v = W'($urandom | $urandom);
      endcase
      ref_pick(v, rt, rf);
      run_case("R3", v, rt, rf);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule